// File: doc/BRIEF.md
# Burst Write Line Cache with Pointer Rollover

This block sits between a serial memory front end and a nonvolatile array. A burst opens with a 13-bit word address. The data bytes that follow are collected in a 64-byte cache made of eight lines of eight bytes. Each byte lands at the current write pointer, and the pointer then steps to the next byte. It moves from the end of one line to the start of the next, and from the end of the last line back to the first. The top seven address bits never change during a burst, so all cached data belongs to one 64-byte region of the array.

Nothing reaches the array while the burst is open. When the stop indication arrives, the block raises busy. It then offers each line that received data on a valid/ready commit port. Each offer carries the line's array address, its eight bytes and a per-byte enable mask, and the lines go out in ascending line order. Once the last line has been accepted, busy drops and all written flags are clear. While busy is high, a new burst, stray data and stop are all refused.

Top module: `wcache_top`

## Requirements
- R1: After reset, busy_o and cmt_valid_o are low and no line is marked as written.
- R2: A start_i pulse seen while the block is idle and not busy opens a burst at start_addr_i. Each wr_vld_i byte is stored at the current pointer, and the pointer's low six bits then increase by one. A byte sent together with stop_i is still stored.
- R3: The top seven bits of start_addr_i stay fixed for the burst. Each commit carries cmt_addr_o = {start_addr_i[12:6], line index}, which is 10 bits wide with the line index in bits 2:0.
- R4: The ninth byte sent from the start of a line wraps the byte offset to 0 and lands in the next line. A byte after line 7 offset 7 lands in line 0 offset 0 and overwrites what was cached there.
- R5: No commit is offered before stop: cmt_valid_o stays low while a burst is open, and it is high only while busy_o is high.
- R6: Only lines that received at least one byte are committed, each one once and in ascending line index order. Bit k of cmt_be_o is set exactly when byte offset k of the line was written, and that byte is carried in cmt_data_o[8k+7:8k].
- R7: A commit transfers on a cycle where cmt_valid_o and cmt_ready_i are both high. While cmt_ready_i is low, the offered address, data and enables stay unchanged.
- R8: busy_o rises in the cycle after stop_i is taken and falls once the last written line has been accepted. start_i, wr_vld_i and stop_i are ignored while busy_o is high, and wr_vld_i and stop_i are ignored when no burst is open.
- R9: All written flags are clear when the commit finishes, so the next burst commits only the lines that it wrote itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Open a burst (only taken when idle) |
| start_addr_i | input | 13 | Starting word address of the burst |
| wr_vld_i | input | 1 | Data byte strobe |
| wr_data_i | input | 8 | Data byte |
| stop_i | input | 1 | End of burst; begin committing |
| busy_o | output | 1 | Commit in progress |
| cmt_valid_o | output | 1 | A line is offered for commit |
| cmt_ready_i | input | 1 | Array accepts the offered line |
| cmt_addr_o | output | 10 | Array line address {upper 7 bits, line index} |
| cmt_data_o | output | 64 | Line bytes, byte k at bits 8k+7:8k |
| cmt_be_o | output | 8 | Written-byte mask of the offered line |

## Verification
The bursts vary in length from zero bytes to more than the whole cache. They start at aligned offsets, at mid-line offsets and at the very last byte. Together they separate three things: plain increment, rollover into the next line, and wrap from line 7 to line 0 with overwrite. The commit port is run with ready always high, with a periodic stall pattern and with ready held low. This shows that ordering and payload do not depend on backpressure. Directed cases send start, data and stop while busy, and data and stop with no burst open. They also check that a burst after a full-cache burst commits only its own line.

// File: rtl/wc_pkg.sv
package wc_pkg;
   typedef enum logic [1:0] {
      WC_IDLE  = 2'd0,
      WC_FILL  = 2'd1,
      WC_DRAIN = 2'd2
   } wc_state_e;
endpackage

// File: rtl/wc_ptr.sv
// Write pointer: fixed upper address bits plus a stepping cache offset.
module wc_ptr #(
   parameter int ADDR_W = 13,
   parameter int OFF_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   output logic [ADDR_W-OFF_W-1:0] hi_o,
   output logic [OFF_W-1:0]  off_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_o  <= '0;
         off_o <= '0;
      end else if (load) begin
         hi_o  <= load_addr[ADDR_W-1:OFF_W];
         off_o <= load_addr[OFF_W-1:0];
      end else if (step) begin
         off_o <= off_o + 1'b1;
      end
   end
endmodule

// File: rtl/wc_store.sv
// Byte storage with one written flag per byte.
module wc_store #(
   parameter int LINES      = 8,
   parameter int LINE_BYTES = 8,
   parameter int DATA_W     = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic [$clog2(LINES*LINE_BYTES)-1:0] wr_off,
   input  logic [DATA_W-1:0] wr_data,
   input  logic clr_en,
   input  logic [$clog2(LINES)-1:0] clr_line,
   output logic [LINES*LINE_BYTES*DATA_W-1:0] line_data,
   output logic [LINES*LINE_BYTES-1:0] line_be
);
   localparam int LINE_W = $clog2(LINES);
   localparam int BYTE_W = $clog2(LINE_BYTES);

   for (genvar l = 0; l < LINES; l++) begin : g_line
      for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
         localparam int IDX = l*LINE_BYTES + b;
         logic hit;
         assign hit = wr_en && (wr_off[LINE_W+BYTE_W-1:BYTE_W] == LINE_W'(l))
                            && (wr_off[BYTE_W-1:0] == BYTE_W'(b));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               line_data[IDX*DATA_W +: DATA_W] <= '0;
               line_be[IDX] <= 1'b0;
            end else if (hit) begin
               line_data[IDX*DATA_W +: DATA_W] <= wr_data;
               line_be[IDX] <= 1'b1;
            end else if (clr_en && clr_line == LINE_W'(l)) begin
               line_be[IDX] <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/wc_pick.sv
// Lowest-index pending line selector.
module wc_pick #(
   parameter int N = 8
) (
   input  logic [N-1:0]         req,
   output logic                 any,
   output logic [$clog2(N)-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N-1; i >= 0; i--) begin
         if (req[i]) idx = ($clog2(N))'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/wcache_top.sv
module wcache_top #(
   parameter int ADDR_W     = 13,
   parameter int DATA_W     = 8,
   parameter int LINE_BYTES = 8,
   parameter int LINES      = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic wr_vld_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic stop_i,
   output logic busy_o,
   output logic cmt_valid_o,
   input  logic cmt_ready_i,
   output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] cmt_addr_o,
   output logic [LINE_BYTES*DATA_W-1:0] cmt_data_o,
   output logic [LINE_BYTES-1:0] cmt_be_o
);
   import wc_pkg::*;

   localparam int LINE_W    = $clog2(LINES);
   localparam int BYTE_W    = $clog2(LINE_BYTES);
   localparam int OFF_W     = LINE_W + BYTE_W;
   localparam int HI_W      = ADDR_W - OFF_W;
   localparam int LINE_BITS = LINE_BYTES * DATA_W;

   if ((1 << LINE_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two");
   end
   if ((1 << BYTE_W) != LINE_BYTES) begin : g_bad_bytes
      $error("LINE_BYTES must be a power of two");
   end
   if (HI_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the cache offset width");
   end

   wc_state_e state;
   logic [HI_W-1:0]  hi;
   logic [OFF_W-1:0] off;
   logic take_start, take_byte, take_stop, xfer;
   logic [LINES*LINE_BITS-1:0]  line_data;
   logic [LINES*LINE_BYTES-1:0] line_be;
   logic [LINES-1:0] pending;
   logic [LINE_BITS-1:0]  data_arr [LINES];
   logic [LINE_BYTES-1:0] be_arr   [LINES];
   logic any_pend;
   logic [LINE_W-1:0] sel;

   assign take_start = (state == WC_IDLE) && start_i;
   assign take_byte  = (state == WC_FILL) && wr_vld_i;
   assign take_stop  = (state == WC_FILL) && stop_i;

   always_ff @(posedge clk) begin
      if (!rst_n) state <= WC_IDLE;
      else begin
         case (state)
            WC_IDLE:  if (take_start) state <= WC_FILL;
            WC_FILL:  if (take_stop)  state <= WC_DRAIN;
            WC_DRAIN: if (!any_pend)  state <= WC_IDLE;
            default:  state <= WC_IDLE;
         endcase
      end
   end

   wc_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(take_start), .load_addr(start_addr_i),
      .step(take_byte), .hi_o(hi), .off_o(off)
   );

   wc_store #(.LINES(LINES), .LINE_BYTES(LINE_BYTES), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(take_byte), .wr_off(off), .wr_data(wr_data_i),
      .clr_en(xfer), .clr_line(sel), .line_data(line_data), .line_be(line_be)
   );

   for (genvar l = 0; l < LINES; l++) begin : g_view
      assign data_arr[l] = line_data[l*LINE_BITS +: LINE_BITS];
      assign be_arr[l]   = line_be[l*LINE_BYTES +: LINE_BYTES];
      assign pending[l]  = |be_arr[l];
   end

   wc_pick #(.N(LINES)) u_pick (.req(pending), .any(any_pend), .idx(sel));

   assign busy_o      = (state == WC_DRAIN);
   assign cmt_valid_o = busy_o && any_pend;
   assign xfer        = cmt_valid_o && cmt_ready_i;
   assign cmt_addr_o  = {hi, sel};
   assign cmt_data_o  = data_arr[sel];
   assign cmt_be_o    = be_arr[sel];
endmodule

// File: rtl/wcache_chk.sv
module wcache_chk #(
   parameter int ADDR_W     = 13,
   parameter int DATA_W     = 8,
   parameter int LINE_BYTES = 8,
   parameter int LINES      = 8
) (
   input logic clk,
   input logic rst_n,
   input logic busy_o,
   input logic cmt_valid_o,
   input logic cmt_ready_i,
   input logic [ADDR_W-$clog2(LINE_BYTES)-1:0] cmt_addr_o,
   input logic [LINE_BYTES*DATA_W-1:0] cmt_data_o,
   input logic [LINE_BYTES-1:0] cmt_be_o
);
   localparam int LINE_W  = $clog2(LINES);
   localparam int CADDR_W = ADDR_W - $clog2(LINE_BYTES);

   logic seen;
   logic [LINE_W-1:0] last_line;

   always_ff @(posedge clk) begin
      if (!rst_n || !busy_o) begin
         seen      <= 1'b0;
         last_line <= '0;
      end else if (cmt_valid_o && cmt_ready_i) begin
         seen      <= 1'b1;
         last_line <= cmt_addr_o[LINE_W-1:0];
      end
   end

   // R5
   valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_valid_o |-> busy_o);

   // R7
   hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_valid_o && !cmt_ready_i) |=>
         (cmt_valid_o && $stable(cmt_addr_o) && $stable(cmt_data_o) && $stable(cmt_be_o)));

   // R6
   ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_valid_o && seen) |-> (cmt_addr_o[LINE_W-1:0] > last_line));

   // R6
   nonempty_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_valid_o |-> (cmt_be_o != '0));

   // R3
   upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(cmt_addr_o[CADDR_W-1:LINE_W]));
endmodule

bind wcache_top wcache_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES), .LINES(LINES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .cmt_valid_o(cmt_valid_o),
   .cmt_ready_i(cmt_ready_i), .cmt_addr_o(cmt_addr_o), .cmt_data_o(cmt_data_o),
   .cmt_be_o(cmt_be_o)
);

// File: tb/sim_wcache_top.sv
`timescale 1ns/1ps
module sim_wcache_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [12:0] start_addr_i = '0;
   logic wr_vld_i = 1'b0;
   logic [7:0] wr_data_i = '0;
   logic stop_i = 1'b0;
   logic busy_o, cmt_valid_o;
   logic cmt_ready_i = 1'b1;
   logic [9:0] cmt_addr_o;
   logic [63:0] cmt_data_o;
   logic [7:0] cmt_be_o;

   always #5 clk = ~clk;

   wcache_top u0 (.*);

   int nchk = 0, nfail = 0, cyc = 0, early = 0, ncmt = 0;
   logic [1:0] rdy_mode = 2'd0;
   logic [9:0]  rec_a [16];
   logic [63:0] rec_d [16];
   logic [7:0]  rec_b [16];

   // Expected cache contents built from the requirements.
   logic [7:0]  em [64];
   logic [63:0] ebit;
   logic [6:0]  ehi;

   // {addr13, len8, seed8, ready mode2}
   localparam logic [30:0] VEC [8] = '{
      {13'h0000, 8'd1,  8'h10, 2'd0},
      {13'h1F40, 8'd8,  8'h20, 2'd0},
      {13'h0A05, 8'd5,  8'h30, 2'd1},
      {13'h1236, 8'd20, 8'h40, 2'd1},
      {13'h003F, 8'd2,  8'h50, 2'd0},
      {13'h0C00, 8'd64, 8'h60, 2'd1},
      {13'h0F3C, 8'd70, 8'h00, 2'd0},
      {13'h1565, 8'd0,  8'h70, 2'd0}
   };

   always @(posedge clk) begin
      cyc <= cyc + 1;
      case (rdy_mode)
         2'd0: cmt_ready_i <= 1'b1;
         2'd1: cmt_ready_i <= (cyc % 3) != 1;
         default: cmt_ready_i <= 1'b0;
      endcase
      if (cyc > 150000) begin
         nfail = nfail + 1;
         $display("FAIL watchdog act=%0d exp=<150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (rst_n && cmt_valid_o && !busy_o) early = early + 1;
      if (rst_n && cmt_valid_o && cmt_ready_i && ncmt < 16) begin
         rec_a[ncmt] = cmt_addr_o;
         rec_d[ncmt] = cmt_data_o;
         rec_b[ncmt] = cmt_be_o;
         ncmt = ncmt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic model_clear();
      ebit = '0;
      for (int i = 0; i < 64; i++) em[i] = 8'h00;
   endtask

   task automatic model_burst(input logic [12:0] a, input int n, input logic [7:0] seed);
      logic [5:0] p;
      ehi = a[12:6];
      p = a[5:0];
      for (int i = 0; i < n; i++) begin
         em[p] = seed + 8'(i);
         ebit[p] = 1'b1;
         p = p + 6'd1;
      end
   endtask

   // Drives start, n bytes (stop with the last byte) and checks R5/R8 around stop.
   task automatic drive_burst(input logic [12:0] a, input int n, input logic [7:0] seed, input bit chk_on);
      @(negedge clk);
      start_i = 1'b1; start_addr_i = a;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < n; i++) begin
         wr_vld_i = 1'b1; wr_data_i = seed + 8'(i); stop_i = (i == n-1);
         if (chk_on && i == n-1)
            chk(!busy_o && !cmt_valid_o, "R5 no commit before stop", {62'd0, busy_o, cmt_valid_o}, 64'd0);
         @(negedge clk);
      end
      if (n == 0) begin
         stop_i = 1'b1;
         @(negedge clk);
      end
      wr_vld_i = 1'b0; stop_i = 1'b0;
      if (chk_on) chk(busy_o == 1'b1, "R8 busy after stop", {63'd0, busy_o}, 64'd1);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 500 && busy_o; i++) @(negedge clk);
   endtask

   task automatic compare(input string tag);
      int k = 0;
      for (int l = 0; l < 8; l++) begin
         logic [7:0] be;
         logic [63:0] ed, msk;
         be = ebit[l*8 +: 8];
         if (be != 8'h00) begin
            ed = '0; msk = '0;
            for (int b = 0; b < 8; b++) begin
               if (be[b]) ed[b*8 +: 8] = em[l*8+b];
            end
            if (k < ncmt) begin
               for (int b = 0; b < 8; b++) if (rec_b[k][b]) msk[b*8 +: 8] = 8'hFF;
               chk(rec_a[k] == {ehi, 3'(l)}, {tag, " R3/R6 commit address"}, 64'(rec_a[k]), 64'({ehi, 3'(l)}));
               chk(rec_b[k] == be, {tag, " R6 byte enables"}, 64'(rec_b[k]), 64'(be));
               chk((rec_d[k] & msk) == ed, {tag, " R2/R4/R7 line data"}, rec_d[k] & msk, ed);
            end
            k++;
         end
      end
      chk(ncmt == k, {tag, " R6/R9 commit count"}, 64'(ncmt), 64'(k));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy_o == 1'b0, "R1 busy at reset", {63'd0, busy_o}, 64'd0);
      chk(cmt_valid_o == 1'b0, "R1 valid at reset", {63'd0, cmt_valid_o}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o == 1'b0 && cmt_valid_o == 1'b0, "R1 idle after reset", {62'd0, busy_o, cmt_valid_o}, 64'd0);

      // Vector table
      for (int v = 0; v < 8; v++) begin
         logic [12:0] a;
         logic [7:0] n, seed;
         logic [1:0] mode;
         {a, n, seed, mode} = VEC[v];
         rdy_mode = mode;
         model_clear();
         model_burst(a, int'(n), seed);
         ncmt = 0;
         drive_burst(a, int'(n), seed, 1'b1);
         wait_idle();
         compare($sformatf("vec%0d", v));
         chk(busy_o == 1'b0, "R8 busy drops after drain", {63'd0, busy_o}, 64'd0);
      end

      // R8: start, bytes and stop refused while busy
      rdy_mode = 2'd2;
      model_clear();
      model_burst(13'h0040, 3, 8'hA0);
      ncmt = 0;
      drive_burst(13'h0040, 3, 8'hA0, 1'b0);
      repeat (5) @(negedge clk);
      chk(busy_o && cmt_valid_o, "R8 busy held under stall", {62'd0, busy_o, cmt_valid_o}, 64'd3);
      drive_burst(13'h0000, 4, 8'h55, 1'b0);
      rdy_mode = 2'd0;
      wait_idle();
      compare("refuse_busy R8");

      // R8: bytes and stop with no burst open
      ncmt = 0;
      @(negedge clk);
      wr_vld_i = 1'b1; wr_data_i = 8'hEE; stop_i = 1'b1;
      @(negedge clk);
      wr_vld_i = 1'b0; stop_i = 1'b0;
      chk(busy_o == 1'b0, "R8 stop without burst ignored", {63'd0, busy_o}, 64'd0);
      repeat (4) @(negedge clk);
      chk(ncmt == 0, "R8 no commit without burst", 64'(ncmt), 64'd0);

      // R9: full cache then a short burst commits only its own line
      model_clear();
      model_burst(13'h0200, 64, 8'h80);
      ncmt = 0;
      drive_burst(13'h0200, 64, 8'h80, 1'b0);
      wait_idle();
      compare("full R9");
      model_clear();
      model_burst(13'h002A, 2, 8'hC0);
      ncmt = 0;
      drive_burst(13'h002A, 2, 8'hC0, 1'b0);
      wait_idle();
      compare("after_full R9");

      chk(early == 0, "R5 valid only while busy", 64'(early), 64'd0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule